// File: doc/BRIEF.md
# Register-Indexed Address Generator

This block forms the effective address of a load, store or prefetch that is addressed as a base register plus an index register. It takes a 64-bit base, a 64-bit index register value and a 3-bit option code. It also takes a scale-enable bit and the log2 of the access size. It returns a 64-bit address and a flag that marks an illegal option code. The block is purely combinational and sits between the register read and the memory pipeline.

The option code has two parts. Bits [1:0] give the width of the index: `10` means the low 32 bits are used and `11` means the full 64 bits are used. Bit [2] gives the signedness of the extension. Byte and halfword widths are not legal for addressing. For the 32-bit width, the low half of the index is zero- or sign-extended. For the 64-bit width, both signedness values pass the index through unchanged, so the two codes give the same address. The index is then shifted left by either zero or the access size in bits of log2, and the result is added to the base.

Top module: `ridx_addr_gen`

## Requirements
- R1: `undef_o` is 1 exactly when bit 1 of `option_i` is 0 (codes 000, 001, 100 and 101), and 0 for codes 010, 011, 110 and 111.
- R2: While `undef_o` is 1, `addr_o` is all zeros, whatever the base and index are.
- R3: Option 010 zero-extends `index_i[31:0]` to 64 bits before the shift.
- R4: Option 110 sign-extends `index_i[31:0]` from bit 31 to 64 bits before the shift.
- R5: Options 011 and 111 both use all 64 bits of `index_i` unchanged, and they give identical addresses for identical inputs.
- R6: The shift amount is 0 when `scale_en_i` is 0 and equals `size_log2_i` (0 to 3) when it is 1. Bits shifted out above bit 63 are lost.
- R7: The sum of the base and the shifted index wraps modulo 2^64.
- R8: In the 32-bit options (010 and 110), `index_i[63:32]` has no effect on `addr_o`.
- R9: The outputs follow the inputs in the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| base_i | input | 64 | Base register value |
| index_i | input | 64 | Index register value |
| option_i | input | 3 | Index option: [2] signed, [1:0] width (10 = 32-bit, 11 = 64-bit) |
| scale_en_i | input | 1 | Shift the index by the access size |
| size_log2_i | input | 2 | log2 of the access size in bytes |
| addr_o | output | 64 | Effective address, or zero when the option is illegal |
| undef_o | output | 1 | Illegal option code |

## Verification
The bench builds the block with its defaults: a 64-bit address, a 32-bit narrow index and a 2-bit size field. These values bring two boundaries within reach: the sign boundary at bit 31 of the index, and carries out of bit 63 from both the shift and the sum. Vectors drive the narrow modes with junk in the upper index half and pair the two 64-bit codes on the same operands. They also cover every illegal code and every shift amount, including a shift of 3 that drops the top index bit. A change of input with no clock edge between it and the sample shows that the path has no register.

// File: rtl/ridx_pkg.sv
package ridx_pkg;
  localparam int unsigned OPT_W = 3;
  // option[1:0] width field
  localparam logic [1:0] WID_WORD  = 2'b10;
  localparam logic [1:0] WID_DWORD = 2'b11;
endpackage

// File: rtl/ridx_index_ext.sv
module ridx_index_ext
  import ridx_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32
) (
  input  logic [ADDR_W-1:0] index_i,
  input  logic [OPT_W-1:0]  option_i,
  output logic [ADDR_W-1:0] ext_o,
  output logic              undef_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  logic [HI_W-1:0] hi_fill;

  always_comb begin
    hi_fill = option_i[2] ? {HI_W{index_i[LO_W-1]}} : '0;
    undef_o = 1'b0;
    unique case (option_i[1:0])
      WID_WORD:  ext_o = {hi_fill, index_i[LO_W-1:0]};
      WID_DWORD: ext_o = index_i;  // both signedness codes pass through
      default: begin
        ext_o   = '0;
        undef_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ridx_index_scale.sv
module ridx_index_scale #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned SZ_W   = 2
) (
  input  logic [ADDR_W-1:0] val_i,
  input  logic              en_i,
  input  logic [SZ_W-1:0]   sz_i,
  output logic [ADDR_W-1:0] val_o
);
  logic [SZ_W-1:0] amt;

  // log-stage shifter, one stage per amount bit
  always_comb begin
    amt   = en_i ? sz_i : '0;
    val_o = val_i;
    for (int k = 0; k < int'(SZ_W); k++) begin
      if (amt[k]) val_o = val_o << (1 << k);
    end
  end
endmodule

// File: rtl/ridx_addr_sum.sv
module ridx_addr_sum #(
  parameter int unsigned ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] off_i,
  input  logic              kill_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] sum;

  always_comb begin
    sum    = base_i + off_i;  // carry out dropped
    addr_o = kill_i ? '0 : sum;
  end
endmodule

// File: rtl/ridx_addr_gen.sv
module ridx_addr_gen
  import ridx_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32,
  parameter int unsigned SZ_W   = 2
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [OPT_W-1:0]  option_i,
  input  logic              scale_en_i,
  input  logic [SZ_W-1:0]   size_log2_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              undef_o
);
  logic [ADDR_W-1:0] ext_idx;
  logic [ADDR_W-1:0] scl_idx;
  logic              bad_opt;

  ridx_index_ext #(.ADDR_W(ADDR_W), .LO_W(LO_W)) u_ext (
    .index_i (index_i),
    .option_i(option_i),
    .ext_o   (ext_idx),
    .undef_o (bad_opt)
  );

  ridx_index_scale #(.ADDR_W(ADDR_W), .SZ_W(SZ_W)) u_scl (
    .val_i(ext_idx),
    .en_i (scale_en_i),
    .sz_i (size_log2_i),
    .val_o(scl_idx)
  );

  ridx_addr_sum #(.ADDR_W(ADDR_W)) u_sum (
    .base_i(base_i),
    .off_i (scl_idx),
    .kill_i(bad_opt),
    .addr_o(addr_o)
  );

  assign undef_o = bad_opt;
endmodule

// File: rtl/ridx_addr_gen_chk.sv
module ridx_addr_gen_chk
  import ridx_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned LO_W   = 32,
  parameter int unsigned SZ_W   = 2
) (
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] index_i,
  input logic [OPT_W-1:0]  option_i,
  input logic              scale_en_i,
  input logic [SZ_W-1:0]   size_log2_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              undef_o
);
  localparam int unsigned HI_W = ADDR_W - LO_W;

  logic [ADDR_W-1:0] zx_idx, sx_idx;
  int unsigned       sh;

  always_comb begin
    zx_idx = {{HI_W{1'b0}}, index_i[LO_W-1:0]};
    sx_idx = {{HI_W{index_i[LO_W-1]}}, index_i[LO_W-1:0]};
    sh     = scale_en_i ? int'(size_log2_i) : 0;

    p_undef_code_r1: assert (undef_o == !option_i[1]);
    if (undef_o) begin
      p_undef_zero_r2: assert (addr_o == '0);
    end
    if (option_i == 3'b010) begin
      p_zext_r3: assert (addr_o == base_i + (zx_idx << sh));
    end
    if (option_i == 3'b110) begin
      p_sext_r4: assert (addr_o == base_i + (sx_idx << sh));
    end
    if (option_i[1:0] == 2'b11) begin
      p_full_idx_r5: assert (addr_o == base_i + (index_i << sh));
    end
  end
endmodule

bind ridx_addr_gen ridx_addr_gen_chk #(
  .ADDR_W(ADDR_W), .LO_W(LO_W), .SZ_W(SZ_W)
) u_chk (.*);

// File: tb/ridx_addr_gen_test.sv
module ridx_addr_gen_test;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [63:0] base;
    logic [63:0] idx;
    logic [2:0]  opt;
    logic        en;
    logic [1:0]  sz;
    logic [63:0] exp_addr;
    logic        exp_undef;
    logic [15:0] tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    // R3/R8: zero-extend, junk upper half, x8
    '{64'h0000_0000_0000_1000, 64'hFFFF_FFFF_0000_0010, 3'b010, 1'b1, 2'd3, 64'h0000_0000_0000_1080, 1'b0, "R3"},
    // R4: negative word index, x4
    '{64'h0000_0000_0000_1000, 64'h0000_0000_FFFF_FFF0, 3'b110, 1'b1, 2'd2, 64'h0000_0000_0000_0FC0, 1'b0, "R4"},
    // R8: sign mode, positive word, upper half junk, no scale
    '{64'h0000_0000_0000_1000, 64'hFFFF_FFFF_7FFF_FFFF, 3'b110, 1'b0, 2'd3, 64'h0000_0000_8000_0FFF, 1'b0, "R8"},
    // R5: full index, both codes
    '{64'h0000_0000_0000_1000, 64'h0000_0001_0000_0002, 3'b011, 1'b1, 2'd1, 64'h0000_0002_0000_1004, 1'b0, "R5"},
    '{64'h0000_0000_0000_1000, 64'h0000_0001_0000_0002, 3'b111, 1'b1, 2'd1, 64'h0000_0002_0000_1004, 1'b0, "R5"},
    // R6: scale disabled ignores size; size 0
    '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_0005, 3'b011, 1'b0, 2'd3, 64'h0000_0000_0000_0105, 1'b0, "R6"},
    '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_0005, 3'b011, 1'b1, 2'd0, 64'h0000_0000_0000_0105, 1'b0, "R6"},
    '{64'h0000_0000_0000_0100, 64'h0000_0000_0000_0005, 3'b111, 1'b1, 2'd2, 64'h0000_0000_0000_0114, 1'b0, "R6"},
    // R7: base wrap
    '{64'hFFFF_FFFF_FFFF_FFF0, 64'h0000_0000_0000_0020, 3'b111, 1'b0, 2'd0, 64'h0000_0000_0000_0010, 1'b0, "R7"},
    // R1/R2: illegal codes
    '{64'h0000_0000_0000_1000, 64'h0000_0000_0000_0007, 3'b000, 1'b1, 2'd3, 64'h0, 1'b1, "R1"},
    '{64'h0000_0000_0000_1000, 64'h0000_0000_0000_0007, 3'b001, 1'b0, 2'd0, 64'h0, 1'b1, "R2"},
    '{64'hDEAD_BEEF_0000_1000, 64'h1234_5678_9ABC_DEF0, 3'b100, 1'b1, 2'd1, 64'h0, 1'b1, "R1"},
    '{64'hDEAD_BEEF_0000_1000, 64'h1234_5678_9ABC_DEF0, 3'b101, 1'b1, 2'd2, 64'h0, 1'b1, "R2"},
    // R3: all-ones word zero-extended, x8 carries past bit 31
    '{64'h0, 64'h0000_0000_FFFF_FFFF, 3'b010, 1'b1, 2'd3, 64'h0000_0007_FFFF_FFF8, 1'b0, "R3"},
    // R4/R7: -1 x8 plus 0x10 wraps to 8
    '{64'h0000_0000_0000_0010, 64'h0000_0000_FFFF_FFFF, 3'b110, 1'b1, 2'd3, 64'h0000_0000_0000_0008, 1'b0, "R4"},
    // R6: top index bit shifted out
    '{64'h0, 64'h8000_0000_0000_0001, 3'b111, 1'b1, 2'd3, 64'h0000_0000_0000_0008, 1'b0, "R6"}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] base_i = '0, index_i = '0;
  logic [2:0]  option_i = '0;
  logic        scale_en_i = 1'b0;
  logic [1:0]  size_log2_i = '0;
  logic [63:0] addr_o;
  logic        undef_o;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ridx_addr_gen uut (
    .base_i(base_i), .index_i(index_i), .option_i(option_i),
    .scale_en_i(scale_en_i), .size_log2_i(size_log2_i),
    .addr_o(addr_o), .undef_o(undef_o)
  );

  task automatic check(string tag, logic [63:0] a, logic [63:0] ea, logic u, logic eu);
    n_cmp++;
    if (a !== ea || u !== eu) begin
      n_bad++;
      $display("FAIL %s: addr=%h undef=%b expected addr=%h undef=%b", tag, a, u, ea, eu);
    end
  endtask

  task automatic drive(logic [63:0] b, logic [63:0] x, logic [2:0] o, logic e, logic [1:0] s);
    base_i = b; index_i = x; option_i = o; scale_en_i = e; size_log2_i = s;
  endtask

  initial begin
    logic [63:0] a_lo, a_hi;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", addr_o, 64'h0, undef_o, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(posedge clk); #1;
      drive(VEC[i].base, VEC[i].idx, VEC[i].opt, VEC[i].en, VEC[i].sz);
      @(negedge clk);
      check(string'(VEC[i].tag), addr_o, VEC[i].exp_addr, undef_o, VEC[i].exp_undef);
    end

    // R5: sweep sizes, 011 vs 111 on same operands
    for (int s = 0; s < 4; s++) begin
      @(posedge clk); #1;
      drive(64'h0123_4567_89AB_CDEF, 64'hF000_0000_8000_0003, 3'b011, 1'b1, 2'(s));
      @(negedge clk); a_lo = addr_o;
      drive(64'h0123_4567_89AB_CDEF, 64'hF000_0000_8000_0003, 3'b111, 1'b1, 2'(s));
      #1; a_hi = addr_o;
      check("R5 pair", a_hi, a_lo, undef_o, 1'b0);
    end

    // R8: upper index half changes, address holds
    @(posedge clk); #1;
    drive(64'h40, 64'h0000_0000_0000_0004, 3'b010, 1'b1, 2'd2);
    #1; a_lo = addr_o;
    index_i = 64'hA5A5_A5A5_0000_0004;
    #1;
    check("R8 upper ignored", addr_o, a_lo, undef_o, 1'b0);
    check("R8 value", addr_o, 64'h50, undef_o, 1'b0);

    // R9: output follows input with no clock edge between
    @(posedge clk); #1;
    drive(64'h0, 64'h7, 3'b011, 1'b0, 2'd0);
    #1;
    check("R9 first", addr_o, 64'h7, undef_o, 1'b0);
    option_i = 3'b001;
    #1;
    check("R9 second", addr_o, 64'h0, undef_o, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule